// File: doc/BRIEF.md
# External DMA Request Synchronizer

This block sits between the active-low DMA request pins driven by external peripherals and the hardware handshaking interfaces of a DMA controller. A peripheral pulls its pin low when its data threshold is reached. The pin is asynchronous to the controller, so the block first passes it through a flip-flop synchronizer chain in the controller clock domain. It then watches the synchronized level for the transition from inactive to asserted. That transition raises an internal request towards the controller.

The internal request stays high until the controller acknowledges it on the same handshaking interface. It does not follow the pin. After an acknowledge, the channel launches nothing more until the synchronized pin has gone back to its inactive level. A single long assertion therefore produces exactly one transfer request.

The request pins map in order onto a contiguous range of handshaking interfaces: pin 0 drives interface 1, pin 1 drives interface 2, and so on. The interfaces outside that range (interface 0 by default) never raise a request.

Top module: `xdreq_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `hs_req` is all zero. Reset clears a pending request, and every synchronizer stage resets to the inactive (high) pin level, so a pin held high through reset produces no request afterwards.
- R2: Pin `dreq_n_pin[i]` drives only `hs_req[HS_BASE+i]` (`HS_BASE` = 1 by default). A pin that is stable low before a rising clock edge, following an inactive period, raises the request right after the third rising edge, counting that one (`SYNC_STAGES`+1 edges).
- R3: A raised request stays high until `hs_ack` of the same interface is sampled high on a rising edge. It is low right after that edge.
- R4: A pin held low across the acknowledge raises no further request, however long it stays low.
- R5: Once the synchronized pin has been high after an acknowledge, a new high-to-low transition raises a new request with the R2 latency.
- R6: Pin activity while a request is pending is ignored. A high-then-low pulse during the pending period does not produce a second request after the acknowledge.
- R7: `hs_ack` has no effect on an interface with no pending request. A later assertion on that interface is still serviced normally.
- R8: Handshaking interfaces outside `HS_BASE`..`HS_BASE+NUM_PINS-1` keep `hs_req` low at all times.
- R9: Channels are independent. Pins asserted in the same cycle raise their requests in the same cycle, and each is cleared only by its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_n_pin | input | NUM_PINS | Asynchronous active-low request pins from peripherals |
| hs_ack | input | NUM_HS | Per-interface acknowledge from the DMA controller |
| hs_req | output | NUM_HS | Registered per-interface request to the DMA controller |

## Verification
On every cycle the assertions check four things: a request holds until its acknowledge and drops right after one, a rising request always has the pin low `SYNC_STAGES`+1 samples earlier, and a dropped request never rises again in the very next cycle. Only the bench scenarios can show the history-dependent behaviour: one request per long assertion, re-arming only after the pin has gone inactive, pulses during a pending request being swallowed, and acknowledges to idle interfaces being harmless. The bench also covers the exact latency, the pin-to-interface mapping and several channels firing together.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  // Per-channel request state
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,  // waiting for an inactive-to-active transition
    ST_PENDING = 2'd1,  // request presented, waiting for acknowledge
    ST_SPENT   = 2'd2   // acknowledged, waiting for pin to go inactive
  } chan_state_t;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int   WIDTH   = 4,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dreq_chan.sv
module dreq_chan
  import dreq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic act,    // synchronized, active-high request level
  input  logic ack,
  output logic req
);

  chan_state_t state_q, state_d;
  logic        prev_q;
  logic        rise;

  assign rise = act & ~prev_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:   if (rise) state_d = ST_PENDING;
      ST_PENDING: if (ack)  state_d = ST_SPENT;
      ST_SPENT:   if (!act) state_d = ST_ARMED;
      default:              state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARMED;
      prev_q  <= 1'b0;
      req     <= 1'b0;
    end else begin
      state_q <= state_d;
      prev_q  <= act;
      req     <= (state_d == ST_PENDING);
    end
  end

endmodule

// File: rtl/xdreq_bridge.sv
module xdreq_bridge #(
  parameter int NUM_PINS    = 4,
  parameter int NUM_HS      = 5,
  parameter int HS_BASE     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] dreq_n_pin,
  input  logic [NUM_HS-1:0]   hs_ack,
  output logic [NUM_HS-1:0]   hs_req
);

  localparam int HS_END = HS_BASE + NUM_PINS;

  logic [NUM_PINS-1:0] pin_n_s;

  dreq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(dreq_n_pin),
    .q_sync (pin_n_s)
  );

  for (genvar j = 0; j < NUM_HS; j++) begin : g_hs
    if (j >= HS_BASE && j < HS_END) begin : g_mapped
      dreq_chan u_chan (
        .clk(clk),
        .rst(rst),
        .act(~pin_n_s[j-HS_BASE]),
        .ack(hs_ack[j]),
        .req(hs_req[j])
      );
    end else begin : g_unmapped
      logic unused_ack;
      assign unused_ack = hs_ack[j];
      assign hs_req[j]  = 1'b0;
    end
  end

endmodule

// File: rtl/dreq_chk.sv
module dreq_chk #(
  parameter int NUM_PINS    = 4,
  parameter int NUM_HS      = 5,
  parameter int HS_BASE     = 1,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] dreq_n_pin,
  input logic [NUM_HS-1:0]   hs_ack,
  input logic [NUM_HS-1:0]   hs_req
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (hs_req == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hs_req[HS_BASE+i] && !hs_ack[HS_BASE+i]) |=> hs_req[HS_BASE+i]);
    // R3
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (hs_req[HS_BASE+i] && hs_ack[HS_BASE+i]) |=> !hs_req[HS_BASE+i]);
    // R2
    launch_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_req[HS_BASE+i]) |-> !$past(dreq_n_pin[i], SYNC_STAGES+1));
    // R4
    rearm_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hs_req[HS_BASE+i]) |=> !hs_req[HS_BASE+i]);
  end

endmodule

bind xdreq_bridge dreq_chk #(
  .NUM_PINS   (NUM_PINS),
  .NUM_HS     (NUM_HS),
  .HS_BASE    (HS_BASE),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dreq_n_pin(dreq_n_pin),
  .hs_ack    (hs_ack),
  .hs_req    (hs_req)
);

// File: tb/sim_xdreq_bridge.sv
module sim_xdreq_bridge;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dreq_n_pin = 4'hF;
  logic [4:0] hs_ack = '0;
  logic [4:0] hs_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xdreq_bridge u0 (
    .clk(clk), .rst(rst), .dreq_n_pin(dreq_n_pin), .hs_ack(hs_ack), .hs_req(hs_req)
  );

  // Vector: [10] pin 0 asserted (drives low), [9:5] hs_ack, [4:0] expected hs_req
  // after the edge that samples these inputs. Pin 0 maps to interface 1.
  localparam int NV = 24;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 5'b00000, 5'b00000},  // 0 idle
    {1'b1, 5'b00000, 5'b00000},  // 1 pin falls
    {1'b1, 5'b00000, 5'b00000},  // 2
    {1'b1, 5'b00000, 5'b00010},  // 3 R2 third edge
    {1'b1, 5'b00000, 5'b00010},  // 4 R3 hold
    {1'b1, 5'b00010, 5'b00000},  // 5 R3 ack
    {1'b1, 5'b00000, 5'b00000},  // 6 R4 still low
    {1'b1, 5'b00000, 5'b00000},  // 7 R4
    {1'b0, 5'b00000, 5'b00000},  // 8 pin released
    {1'b1, 5'b00000, 5'b00000},  // 9 re-asserted
    {1'b1, 5'b00000, 5'b00000},  // 10
    {1'b1, 5'b00000, 5'b00010},  // 11 R5 new request
    {1'b0, 5'b00000, 5'b00010},  // 12 R6 pulse while pending
    {1'b1, 5'b00000, 5'b00010},  // 13 R6
    {1'b1, 5'b00010, 5'b00000},  // 14 ack
    {1'b1, 5'b00000, 5'b00000},  // 15 R6 swallowed edge
    {1'b1, 5'b00000, 5'b00000},  // 16
    {1'b0, 5'b00000, 5'b00000},  // 17 release
    {1'b0, 5'b00000, 5'b00000},  // 18
    {1'b1, 5'b00000, 5'b00000},  // 19 assert
    {1'b1, 5'b00000, 5'b00000},  // 20
    {1'b1, 5'b00000, 5'b00010},  // 21 R5
    {1'b1, 5'b00010, 5'b00000},  // 22 ack
    {1'b0, 5'b00011, 5'b00000}   // 23 R7 ack with nothing pending
  };

  task automatic check(input logic [4:0] exp, input string tag);
    checks++;
    if (hs_req !== exp) begin
      errors++;
      $display("FAIL %s: hs_req=%b expected %b", tag, hs_req, exp);
    end
  endtask

  task automatic step(input logic [3:0] pins, input logic [4:0] ack);
    @(negedge clk);
    dreq_n_pin = pins;
    hs_ack     = ack;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state with pins inactive
    repeat (3) @(posedge clk);
    #1 check(5'b00000, "R1 during reset");
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(4'hF, 5'b00000);
      check(5'b00000, "R1 after reset");
    end

    // Table walk on pin 0 / interface 1 (R2..R7)
    for (int v = 0; v < NV; v++) begin
      step({3'b111, ~VEC[v][10]}, VEC[v][9:5]);
      check(VEC[v][4:0], $sformatf("R2-6 table vector %0d", v));
    end
    repeat (3) step(4'hF, 5'b00000);

    // R7: acks everywhere while idle, then pin 2 still serviced; R2 mapping
    step(4'hF, 5'b11111);
    check(5'b00000, "R7 idle ack");
    step(4'b1011, 5'b00000);
    check(5'b00000, "R2 latency edge 1");
    step(4'b1011, 5'b00000);
    check(5'b00000, "R2 latency edge 2");
    step(4'b1011, 5'b00000);
    check(5'b01000, "R2 pin 2 to interface 3");
    step(4'hF, 5'b01000);
    check(5'b00000, "R3 ack interface 3");
    repeat (3) step(4'hF, 5'b00000);

    // R9: all pins together; R8: interface 0 stays low
    step(4'h0, 5'b00001);
    step(4'h0, 5'b00001);
    check(5'b00000, "R9 before latency");
    step(4'h0, 5'b00001);
    check(5'b11110, "R9 all channels R8 interface 0 low");
    step(4'h0, 5'b00100);
    check(5'b11010, "R9 independent ack");
    step(4'hF, 5'b11000);
    check(5'b00010, "R9 partial ack");

    // R1: reset clears pending request; pins high through reset give nothing
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check(5'b00000, "R1 reset clears pending");
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(4'hF, 5'b00000);
      check(5'b00000, "R1 no spurious request");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule